// File: doc/BRIEF.md
# Four-Bit Asynchronous Serial Receiver with Active-Low Handshake

This block turns an asynchronous serial line into a 4-bit parallel word. A frame on the line is a low start bit, four data bits with the least significant bit first, and a high stop bit. The block is clocked at sixteen times the serial bit rate, so every clock edge is one sampling tick. The line passes through a synchroniser. The receiver then finds the falling edge of the start bit, confirms the start bit at its midpoint and samples each data bit near the middle of its bit period. It accepts the frame only if the stop bit reads high.

An accepted nibble is placed on a held parallel output, and an active-low "word ready" flag goes low. A consuming device pulls an active-low read strobe to take the word, which releases the flag. If another complete frame arrives before the read, the newest nibble replaces the old one and an active-low overrun flag goes low. The overrun flag stays low until the next read, which clears both flags.

Top module: `rxn_serial4_rx`

## Requirements
- R1: While `rst` is high, and after it is released with no traffic, `data_o` is 4'h0, `avail_n_o` is 1 and `ovr_n_o` is 1.
- R2: The first data bit after the start bit lands in `data_o[0]`, and the following bits land in `data_o[1]`, `data_o[2]` and `data_o[3]` in order.
- R3: Number the first rising edge at which `rx_i` is already low as edge 0. For a valid frame, `avail_n_o` is still 1 after edge 89 and is 0 after edge 90. This timing uses 2 synchroniser stages and 16 ticks per bit.
- R4: `data_o` changes only when a valid frame completes. Between frames it holds its value.
- R5: A rising edge that sees `rd_n_i` at 0, with no frame completing on that edge, leaves `avail_n_o` at 1 after it.
- R6: If a valid frame completes while `avail_n_o` is 0 and `rd_n_i` is 1, then `ovr_n_o` goes to 0 and `data_o` takes the newest nibble. `ovr_n_o` stays 0 until a read, and a read returns both `ovr_n_o` and `avail_n_o` to 1.
- R7: If `rx_i` is high again at the start-bit midpoint, the falling edge is dropped. No word is delivered and the outputs are unchanged.
- R8: A frame whose stop bit reads low is discarded. `data_o`, `avail_n_o` and `ovr_n_o` keep their values.
- R9: The receiver is idle again after the stop-bit sample. A start bit that follows the stop bit with no idle gap is received as a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, sixteen ticks per serial bit |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| rd_n_i | input | 1 | Read strobe from the consumer, active low, sampled on `clk` |
| data_o | output | 4 | Last accepted nibble |
| avail_n_o | output | 1 | Word ready flag, active low |
| ovr_n_o | output | 1 | Overrun flag, active low |

## Verification
Two latencies matter here. A frame becomes visible on the outputs 90 edges after the first edge that sees the start bit low: 2 synchroniser edges, 8 ticks to the start-bit midpoint and 16 ticks for each of the four data bits and the stop bit. A read is visible on the outputs one edge after it is sampled. The bench drives its inputs on falling edges and counts falling edges from the drive of the start bit. It checks `avail_n_o` exactly at counts 90 and 91 to catch an off-by-one tick. It samples the read results at the falling edge that follows the edge on which the read was taken. The overrun, glitch and bad-stop cases are checked only after the frame that could have disturbed the outputs has fully passed.

// File: rtl/rxn_pkg.sv
package rxn_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_t;
endpackage

// File: rtl/rxn_sync.sv
module rxn_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rxn_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{RST_VAL}};
      else     chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxn_framer.sv
module rxn_framer
   import rxn_pkg::*;
#(
   parameter int DATA_W    = 4,
   parameter int OSR       = 16,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_i,
   output logic [DATA_W-1:0] nib_o,
   output logic              commit_o
);
   localparam int CNT_W = $clog2(OSR);
   localparam int BIT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);
   localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("rxn_framer: OSR must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("rxn_framer: DATA_W must be at least 2");
   end

   rx_state_t         state_q;
   logic [CNT_W-1:0]  tick_q;
   logic [BIT_W-1:0]  nbit_q;
   logic [DATA_W-1:0] shreg_q;
   logic [DATA_W-1:0] shift_next;
   logic              line_prev_q;
   logic              fall_w;

   // Shift direction chosen at elaboration
   if (LSB_FIRST) begin : g_lsb
      assign shift_next = {line_i, shreg_q[DATA_W-1:1]};
   end else begin : g_msb
      assign shift_next = {shreg_q[DATA_W-2:0], line_i};
   end

   assign fall_w = line_prev_q & ~line_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= RX_IDLE;
         tick_q      <= '0;
         nbit_q      <= '0;
         shreg_q     <= '0;
         line_prev_q <= 1'b1;
      end else begin
         line_prev_q <= line_i;
         unique case (state_q)
            RX_IDLE: begin
               tick_q <= '0;
               if (fall_w) state_q <= RX_START;
            end
            RX_START: begin
               if (tick_q == HALF_LAST) begin
                  tick_q  <= '0;
                  nbit_q  <= '0;
                  state_q <= line_i ? RX_IDLE : RX_DATA;
               end else begin
                  tick_q <= tick_q + 1'b1;
               end
            end
            RX_DATA: begin
               if (tick_q == FULL_LAST) begin
                  tick_q  <= '0;
                  shreg_q <= shift_next;
                  if (nbit_q == BIT_LAST) state_q <= RX_STOP;
                  else                    nbit_q  <= nbit_q + 1'b1;
               end else begin
                  tick_q <= tick_q + 1'b1;
               end
            end
            RX_STOP: begin
               if (tick_q == FULL_LAST) begin
                  tick_q  <= '0;
                  state_q <= RX_IDLE;
               end else begin
                  tick_q <= tick_q + 1'b1;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   assign commit_o = (state_q == RX_STOP) && (tick_q == FULL_LAST) && line_i;
   assign nib_o    = shreg_q;

   // R3: a completed frame spans many ticks, so commits never come back to back
   assert_commit_spacing_R3: assert property (@(posedge clk) disable iff (rst)
      commit_o |=> !commit_o);
   // R9: after the stop sample the receiver is idle again
   assert_idle_after_stop_R9: assert property (@(posedge clk) disable iff (rst)
      commit_o |=> (state_q == RX_IDLE));
endmodule

// File: rtl/rxn_handshake.sv
module rxn_handshake #(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              commit_i,
   input  logic [DATA_W-1:0] nib_i,
   input  logic              rd_n_i,
   output logic [DATA_W-1:0] data_o,
   output logic              avail_n_o,
   output logic              ovr_n_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         data_o    <= '0;
         avail_n_o <= 1'b1;
         ovr_n_o   <= 1'b1;
      end else begin
         if (commit_i) data_o <= nib_i;

         if (commit_i)     avail_n_o <= 1'b0;
         else if (!rd_n_i) avail_n_o <= 1'b1;

         if (commit_i && !avail_n_o && rd_n_i) ovr_n_o <= 1'b0;
         else if (!rd_n_i)                     ovr_n_o <= 1'b1;
      end
   end

   assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
      (!rd_n_i && !commit_i) |=> avail_n_o);
   assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
      (commit_i && !avail_n_o && rd_n_i) |=> !ovr_n_o);
   assert_overrun_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!ovr_n_o && rd_n_i) |=> !ovr_n_o);
   assert_overrun_needs_avail_R6: assert property (@(posedge clk) disable iff (rst)
      !ovr_n_o |-> !avail_n_o);
   assert_avail_from_frame_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(avail_n_o) |-> $past(commit_i));
   assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !commit_i |=> $stable(data_o));
endmodule

// File: rtl/rxn_serial4_rx.sv
module rxn_serial4_rx #(
   parameter int DATA_W      = 4,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_i,
   input  logic              rd_n_i,
   output logic [DATA_W-1:0] data_o,
   output logic              avail_n_o,
   output logic              ovr_n_o
);
   logic              line_s;
   logic              commit_w;
   logic [DATA_W-1:0] nib_w;

   rxn_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) sync_i (
      .clk (clk),
      .rst (rst),
      .d_i (rx_i),
      .q_o (line_s)
   );

   rxn_framer #(
      .DATA_W    (DATA_W),
      .OSR       (OSR),
      .LSB_FIRST (LSB_FIRST)
   ) framer_i (
      .clk      (clk),
      .rst      (rst),
      .line_i   (line_s),
      .nib_o    (nib_w),
      .commit_o (commit_w)
   );

   rxn_handshake #(
      .DATA_W (DATA_W)
   ) hs_i (
      .clk       (clk),
      .rst       (rst),
      .commit_i  (commit_w),
      .nib_i     (nib_w),
      .rd_n_i    (rd_n_i),
      .data_o    (data_o),
      .avail_n_o (avail_n_o),
      .ovr_n_o   (ovr_n_o)
   );
endmodule

// File: tb/rxn_serial4_rx_tb_top.sv
module rxn_serial4_rx_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx = 1'b1;
   logic       rd_n = 1'b1;
   logic [3:0] data;
   logic       avail_n;
   logic       ovr_n;
   int         checks = 0;
   int         errors = 0;

   always #4 clk = ~clk;

   rxn_serial4_rx dut_i (
      .clk       (clk),
      .rst       (rst),
      .rx_i      (rx),
      .rd_n_i    (rd_n),
      .data_o    (data),
      .avail_n_o (avail_n),
      .ovr_n_o   (ovr_n)
   );

   // upper nibble: bits sent on the line (bit 0 first); lower nibble: expected data_o
   localparam logic [7:0] VEC [0:7] = '{8'h11, 8'h22, 8'h44, 8'h88,
                                        8'hAA, 8'h55, 8'hFF, 8'h00};

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drives a full frame starting at a falling edge; optional exact-edge check (R3)
   task automatic send_frame(input logic [3:0] nib, input logic stop_bit, input bit timing);
      logic [5:0] bits;
      bits = {stop_bit, nib, 1'b0};
      for (int j = 0; j < 6; j++) begin
         rx = bits[j];
         for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (timing && (16 * j + i + 1) == 90) chk("R3 before edge 90", {3'b0, avail_n}, 4'h1);
            if (timing && (16 * j + i + 1) == 91) chk("R3 after edge 90", {3'b0, avail_n}, 4'h0);
         end
      end
   endtask

   task automatic do_read();
      rd_n = 1'b0;
      @(negedge clk);
      rd_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 data in reset", data, 4'h0);
      chk("R1 avail_n in reset", {3'b0, avail_n}, 4'h1);
      chk("R1 ovr_n in reset", {3'b0, ovr_n}, 4'h1);
      rst = 1'b0;
      repeat (10) @(negedge clk);
      chk("R1 data idle", data, 4'h0);
      chk("R1 avail_n idle", {3'b0, avail_n}, 4'h1);

      // Table walk: R2 bit order, R3 timing, R4 hold, R5 read release
      for (int v = 0; v < 8; v++) begin
         send_frame(VEC[v][7:4], 1'b1, 1'b1);
         chk("R2 nibble", data, VEC[v][3:0]);
         repeat (20) @(negedge clk);
         chk("R4 data held", data, VEC[v][3:0]);
         chk("R6 no overrun on single frame", {3'b0, ovr_n}, 4'h1);
         do_read();
         chk("R5 avail released", {3'b0, avail_n}, 4'h1);
         chk("R4 data held after read", data, VEC[v][3:0]);
         repeat (5) @(negedge clk);
      end

      // R7: start glitch shorter than half a bit
      rx = 1'b0;
      repeat (4) @(negedge clk);
      rx = 1'b1;
      repeat (120) @(negedge clk);
      chk("R7 glitch no word", {3'b0, avail_n}, 4'h1);
      chk("R7 glitch data kept", data, 4'h0);

      // R8: bad stop bit after a good word
      send_frame(4'hA, 1'b1, 1'b1);
      send_frame(4'h5, 1'b0, 1'b0);
      rx = 1'b1;
      repeat (20) @(negedge clk);
      chk("R8 data kept", data, 4'hA);
      chk("R8 avail_n kept", {3'b0, avail_n}, 4'h0);
      chk("R8 no overrun", {3'b0, ovr_n}, 4'h1);
      do_read();
      chk("R8 read after discard", {3'b0, avail_n}, 4'h1);
      repeat (5) @(negedge clk);

      // R6/R9: back-to-back frames with no idle gap, no read in between
      send_frame(4'h3, 1'b1, 1'b1);
      send_frame(4'hC, 1'b1, 1'b0);
      repeat (5) @(negedge clk);
      chk("R9 second frame accepted", data, 4'hC);
      chk("R6 overrun low", {3'b0, ovr_n}, 4'h0);
      chk("R6 avail low", {3'b0, avail_n}, 4'h0);
      repeat (40) @(negedge clk);
      chk("R6 overrun held", {3'b0, ovr_n}, 4'h0);
      do_read();
      chk("R6 read clears overrun", {3'b0, ovr_n}, 4'h1);
      chk("R6 read clears avail", {3'b0, avail_n}, 4'h1);
      chk("R4 data after overrun read", data, 4'hC);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule